// File: doc/BRIEF.md
# CAN receive-status interrupt flag unit

This block keeps the per-mailbox receive bookkeeping of a CAN controller and raises two interrupt flags from it. Each mailbox has a data-pending bit, a remote-pending bit, an unread-status bit, an interrupt mask bit and a collision-policy bit. When a receive-complete strobe names a mailbox that still holds an unconsumed message, the block decides whether the new message is dropped or replaces the old one. If the mailbox is not masked, it records the collision in the unread-status bit and in the overrun flag.

The second flag records bus activity during sleep. The receive line is passed through a synchronizer. A dominant level (0) seen while the controller sleeps sets the wake flag. Both flags are combined with an enable register into a single interrupt line. Software reaches all registers through one write port with a select code. Frame decoding, bit timing and acceptance filtering are done elsewhere. The store and discard outputs tell the receive path what to do with the frame in the same cycle as the strobe.

Top module: `can_rxstat_irq`

## Requirements
- R1: After reset, the data-pending, remote-pending, unread, mailbox-mask and policy vectors are all 0. The flag word `irr` is 0. `irq_mask` is 16'h1200, which disables both flags. `irq` is 0.
- R2: A strobe on a mailbox whose data-pending and remote-pending bits are both 0 drives `rx_store`=1 in that cycle. On the next edge it sets the mailbox's remote-pending bit if `rx_remote`=1, and otherwise its data-pending bit.
- R3: A strobe on a mailbox with either pending bit set is a collision. If that mailbox's mask bit is 0, the next edge sets its unread bit and the overrun flag `irr[9]`. If the mask bit is 1, neither is set.
- R4: On a collision the policy bit decides the outcome. Policy 0 gives `rx_discard`=1, `rx_store`=0, and no pending bit is set. Policy 1 gives `rx_store`=1, `rx_discard`=0, and the pending bit is set as in R2.
- R5: Writes have no effect on `irr[9]`. While some mailbox has its unread bit set and its mask bit 0, `irr[9]` stays set. It clears on the edge after the cycle in which no such mailbox exists and no collision sets it.
- R6: The line `can_rx` passes through two flops. A 0 driven before edge k while `sleep_mode`=1 sets `irr[12]` at edge k+2. Outside sleep, a 0 on the line does not set `irr[12]`.
- R7: Writing select 5 with data bit 12 = 1 clears `irr[12]`, and writing 0 there leaves it unchanged. Every `irr` bit other than 9 and 12, including the reserved bits 11 and 10, reads 0.
- R8: Select codes 0, 1 and 2 are write-1-to-clear on data-pending, remote-pending and unread, one data bit per mailbox. If a clear and a set hit the same bit in the same cycle, the set wins.
- R9: `irq` is (`irr[9]` AND NOT `irq_mask[9]`) OR (`irr[12]` AND NOT `irq_mask[12]`). Select 6 loads `irq_mask` bits 9 and 12; all its other bits read 0.
- R10: Select 3 loads the mailbox-mask vector and select 4 loads the policy vector. Select 7 changes nothing, and `wr_en`=0 ignores the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done | input | 1 | Receive-complete strobe, one cycle |
| rx_mb | input | 4 | Mailbox index of the received frame |
| rx_remote | input | 1 | Received frame is a remote frame |
| sleep_mode | input | 1 | Controller is in sleep mode |
| can_rx | input | 1 | Asynchronous receive line, 0 = dominant |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 data-pending, 1 remote-pending, 2 unread, 3 mailbox mask, 4 policy, 5 flags, 6 flag enable, 7 none |
| wr_data | input | 16 | Write data |
| rx_pend | output | 16 | Data-pending bits per mailbox |
| rfp_pend | output | 16 | Remote-pending bits per mailbox |
| unread | output | 16 | Unread-status bits per mailbox |
| mb_mask | output | 16 | Mailbox interrupt mask bits, 1 = masked |
| nmc_ctl | output | 16 | Collision policy bits, 1 = overwrite |
| irr | output | 16 | Flag word: bit 9 overrun, bit 12 wake |
| irq_mask | output | 16 | Flag enable word, 1 = flag disabled |
| rx_store | output | 1 | Store the current frame (combinational) |
| rx_discard | output | 1 | Drop the current frame (combinational) |
| irq | output | 1 | Masked interrupt line |

## Verification
Several rules are checked on every cycle:
- a collision on an unmasked mailbox leads to the overrun flag and the unread bit;
- the overrun flag holds while any unmasked unread bit remains, and clears once none remains;
- a discard only happens on a collision under the drop policy;
- a stored data frame raises its pending bit;
- a written 0 never clears the wake flag;
- the reserved bits stay 0.

Some behaviour shows only in the bench's scenarios:
- the two-flop latency of wake detection and its gating by sleep;
- set-over-clear priority on the same bit;
- the overwrite path;
- the lag of one cycle in clearing the overrun flag after a mask write;
- that select 7 leaves every register alone.

// File: rtl/can_rxstat_pkg.sv
package can_rxstat_pkg;
   localparam int REG_W    = 16;
   localparam int OVR_BIT  = 9;
   localparam int WAKE_BIT = 12;

   typedef enum logic [2:0] {
      SEL_RXPEND = 3'd0,
      SEL_RFPEND = 3'd1,
      SEL_UNREAD = 3'd2,
      SEL_MBMASK = 3'd3,
      SEL_NMC    = 3'd4,
      SEL_IRR    = 3'd5,
      SEL_IMR    = 3'd6,
      SEL_NONE   = 3'd7
   } wr_sel_e;
endpackage

// File: rtl/rxline_sync.sv
module rxline_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("rxline_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], din};
   end

   assign dout = sh[STAGES-1];
endmodule

// File: rtl/mb_status.sv
module mb_status
   import can_rxstat_pkg::*;
#(
   parameter int NUM_MB = 16,
   localparam int MBW = $clog2(NUM_MB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_done,
   input  logic [MBW-1:0]    rx_mb,
   input  logic              rx_remote,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [NUM_MB-1:0] wr_data,
   output logic [NUM_MB-1:0] rx_pend,
   output logic [NUM_MB-1:0] rfp_pend,
   output logic [NUM_MB-1:0] unread,
   output logic [NUM_MB-1:0] mb_mask,
   output logic [NUM_MB-1:0] nmc_ctl,
   output logic              rx_store,
   output logic              rx_discard,
   output logic              ovr_evt,
   output logic              ovr_hold
);
   logic wr_rxp, wr_rfp, wr_unr, wr_msk, wr_nmc;
   logic [NUM_MB-1:0] hit, coll, keep, ovr_set;

   assign wr_rxp = wr_en && (wr_sel == SEL_RXPEND);
   assign wr_rfp = wr_en && (wr_sel == SEL_RFPEND);
   assign wr_unr = wr_en && (wr_sel == SEL_UNREAD);
   assign wr_msk = wr_en && (wr_sel == SEL_MBMASK);
   assign wr_nmc = wr_en && (wr_sel == SEL_NMC);

   genvar g;
   generate
      for (g = 0; g < NUM_MB; g++) begin : g_mb
         assign hit[g]     = rx_done && (rx_mb == MBW'(g));
         assign coll[g]    = hit[g] && (rx_pend[g] || rfp_pend[g]);
         assign keep[g]    = hit[g] && !(coll[g] && !nmc_ctl[g]);
         assign ovr_set[g] = coll[g] && !mb_mask[g];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rx_pend[g]  <= 1'b0;
               rfp_pend[g] <= 1'b0;
               unread[g]   <= 1'b0;
               mb_mask[g]  <= 1'b0;
               nmc_ctl[g]  <= 1'b0;
            end else begin
               rx_pend[g]  <= (rx_pend[g]  && !(wr_rxp && wr_data[g])) || (keep[g] && !rx_remote);
               rfp_pend[g] <= (rfp_pend[g] && !(wr_rfp && wr_data[g])) || (keep[g] &&  rx_remote);
               unread[g]   <= (unread[g]   && !(wr_unr && wr_data[g])) || ovr_set[g];
               if (wr_msk) mb_mask[g] <= wr_data[g];
               if (wr_nmc) nmc_ctl[g] <= wr_data[g];
            end
         end
      end
   endgenerate

   assign rx_discard = |(coll & ~nmc_ctl);
   assign rx_store   = rx_done && !rx_discard;
   assign ovr_evt    = |ovr_set;
   assign ovr_hold   = |(unread & ~mb_mask);
endmodule

// File: rtl/irq_flags.sv
module irq_flags
   import can_rxstat_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ovr_evt,
   input  logic             ovr_hold,
   input  logic             sleep_mode,
   input  logic             line_sync,
   input  logic             wr_irr,
   input  logic             wr_imr,
   input  logic             d_ovr,
   input  logic             d_wake,
   output logic [REG_W-1:0] irr,
   output logic [REG_W-1:0] irq_mask,
   output logic             irq
);
   logic ovr_q, wake_q, en_ovr_n, en_wake_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q     <= 1'b0;
         wake_q    <= 1'b0;
         en_ovr_n  <= 1'b1;
         en_wake_n <= 1'b1;
      end else begin
         ovr_q  <= ovr_evt || (ovr_q && ovr_hold);
         wake_q <= (sleep_mode && !line_sync) || (wake_q && !(wr_irr && d_wake));
         if (wr_imr) begin
            en_ovr_n  <= d_ovr;
            en_wake_n <= d_wake;
         end
      end
   end

   always_comb begin
      irr                = '0;
      irr[OVR_BIT]       = ovr_q;
      irr[WAKE_BIT]      = wake_q;
      irq_mask           = '0;
      irq_mask[OVR_BIT]  = en_ovr_n;
      irq_mask[WAKE_BIT] = en_wake_n;
   end

   assign irq = (ovr_q && !en_ovr_n) || (wake_q && !en_wake_n);
endmodule

// File: rtl/can_rxstat_irq.sv
module can_rxstat_irq
   import can_rxstat_pkg::*;
#(
   parameter int NUM_MB      = 16,
   parameter int SYNC_STAGES = 2,
   localparam int MBW = $clog2(NUM_MB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_done,
   input  logic [MBW-1:0]    rx_mb,
   input  logic              rx_remote,
   input  logic              sleep_mode,
   input  logic              can_rx,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [REG_W-1:0]  wr_data,
   output logic [NUM_MB-1:0] rx_pend,
   output logic [NUM_MB-1:0] rfp_pend,
   output logic [NUM_MB-1:0] unread,
   output logic [NUM_MB-1:0] mb_mask,
   output logic [NUM_MB-1:0] nmc_ctl,
   output logic [REG_W-1:0]  irr,
   output logic [REG_W-1:0]  irq_mask,
   output logic              rx_store,
   output logic              rx_discard,
   output logic              irq
);
   generate
      if (NUM_MB < 2 || NUM_MB > REG_W || (1 << MBW) != NUM_MB) begin : g_bad
         $error("can_rxstat_irq: NUM_MB must be a power of two between 2 and REG_W");
      end
   endgenerate

   logic line_sync, ovr_evt, ovr_hold;

   rxline_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(can_rx), .dout(line_sync)
   );

   mb_status #(.NUM_MB(NUM_MB)) u_mb (
      .clk(clk), .rst_n(rst_n),
      .rx_done(rx_done), .rx_mb(rx_mb), .rx_remote(rx_remote),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data[NUM_MB-1:0]),
      .rx_pend(rx_pend), .rfp_pend(rfp_pend), .unread(unread),
      .mb_mask(mb_mask), .nmc_ctl(nmc_ctl),
      .rx_store(rx_store), .rx_discard(rx_discard),
      .ovr_evt(ovr_evt), .ovr_hold(ovr_hold)
   );

   irq_flags u_flags (
      .clk(clk), .rst_n(rst_n),
      .ovr_evt(ovr_evt), .ovr_hold(ovr_hold),
      .sleep_mode(sleep_mode), .line_sync(line_sync),
      .wr_irr(wr_en && (wr_sel == SEL_IRR)),
      .wr_imr(wr_en && (wr_sel == SEL_IMR)),
      .d_ovr(wr_data[OVR_BIT]), .d_wake(wr_data[WAKE_BIT]),
      .irr(irr), .irq_mask(irq_mask), .irq(irq)
   );
endmodule

// File: rtl/can_rxstat_irq_chk.sv
module can_rxstat_irq_chk #(
   parameter int NUM_MB = 16,
   localparam int MBW = $clog2(NUM_MB)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_done,
   input logic [MBW-1:0]    rx_mb,
   input logic              rx_remote,
   input logic              wr_en,
   input logic [2:0]        wr_sel,
   input logic [15:0]       wr_data,
   input logic [NUM_MB-1:0] rx_pend,
   input logic [NUM_MB-1:0] rfp_pend,
   input logic [NUM_MB-1:0] unread,
   input logic [NUM_MB-1:0] mb_mask,
   input logic [NUM_MB-1:0] nmc_ctl,
   input logic [15:0]       irr,
   input logic              rx_store,
   input logic              rx_discard
);
   logic busy_now, ovr_cause;
   assign busy_now  = rx_pend[rx_mb] || rfp_pend[rx_mb];
   assign ovr_cause = rx_done && busy_now && !mb_mask[rx_mb];

   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_cause |=> (irr[9] && unread[$past(rx_mb)]));                                  // R3
   AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irr[9] && ((unread & ~mb_mask) != '0)) |=> irr[9]);                               // R5
   AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_cause && ((unread & ~mb_mask) == '0)) |=> !irr[9]);                          // R5
   AST_DISCARD_WHY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_discard |-> (rx_done && busy_now && !nmc_ctl[rx_mb] && !rx_store));             // R4
   AST_STORE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_store && !rx_remote) |=> rx_pend[$past(rx_mb)]);                               // R2
   AST_WAKE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (irr[12] && !(wr_en && wr_sel == 3'd5 && wr_data[12])) |=> irr[12]);               // R7
   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (irr[11:10] == 2'b00));                                                            // R7
endmodule

bind can_rxstat_irq can_rxstat_irq_chk #(.NUM_MB(NUM_MB)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_mb(rx_mb), .rx_remote(rx_remote),
   .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .rx_pend(rx_pend), .rfp_pend(rfp_pend), .unread(unread), .mb_mask(mb_mask),
   .nmc_ctl(nmc_ctl), .irr(irr), .rx_store(rx_store), .rx_discard(rx_discard)
);

// File: tb/can_rxstat_irq_tb.sv
`timescale 1ns/100ps
module can_rxstat_irq_tb;
   localparam int N = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rx_done = 0, rx_remote = 0, sleep_mode = 0, can_rx = 1, wr_en = 0;
   logic [3:0] rx_mb = '0;
   logic [2:0] wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic [N-1:0] rx_pend, rfp_pend, unread, mb_mask, nmc_ctl;
   logic [15:0] irr, irq_mask;
   logic rx_store, rx_discard, irq;

   int errors = 0, checks = 0;
   bit done = 0;

   always #2 clk = ~clk;

   can_rxstat_irq u_dut (
      .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_mb(rx_mb), .rx_remote(rx_remote),
      .sleep_mode(sleep_mode), .can_rx(can_rx), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rx_pend(rx_pend), .rfp_pend(rfp_pend), .unread(unread),
      .mb_mask(mb_mask), .nmc_ctl(nmc_ctl), .irr(irr), .irq_mask(irq_mask),
      .rx_store(rx_store), .rx_discard(rx_discard), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   logic [N-1:0] m_rxp, m_rfp, m_unr, m_msk, m_nmc;
   bit m_ovr, m_wake, m_ien_ovr, m_ien_wake, m_s1, m_s2;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_rxp = 0; m_rfp = 0; m_unr = 0; m_msk = 0; m_nmc = 0;
         m_ovr = 0; m_wake = 0; m_ien_ovr = 1; m_ien_wake = 1; m_s1 = 1; m_s2 = 1;
      end else begin
         bit collide, drop, keep, evt, hold;
         logic [N-1:0] sel1, clr;
         sel1    = N'(1) << rx_mb;
         collide = rx_done && (m_rxp[rx_mb] || m_rfp[rx_mb]);
         drop    = collide && !m_nmc[rx_mb];
         keep    = rx_done && !drop;
         evt     = collide && !m_msk[rx_mb];
         hold    = (m_unr & ~m_msk) != 0;
         clr     = wr_data[N-1:0];
         if (wr_en && wr_sel == 0) m_rxp &= ~clr;
         if (wr_en && wr_sel == 1) m_rfp &= ~clr;
         if (wr_en && wr_sel == 2) m_unr &= ~clr;
         if (keep && !rx_remote) m_rxp |= sel1;
         if (keep &&  rx_remote) m_rfp |= sel1;
         if (evt) m_unr |= sel1;
         if (wr_en && wr_sel == 3) m_msk = clr;
         if (wr_en && wr_sel == 4) m_nmc = clr;
         m_ovr = evt || (m_ovr && hold);
         if (wr_en && wr_sel == 5 && wr_data[12]) m_wake = 0;
         if (sleep_mode && !m_s2) m_wake = 1;
         if (wr_en && wr_sel == 6) begin m_ien_ovr = wr_data[9]; m_ien_wake = wr_data[12]; end
         m_s2 = m_s1; m_s1 = can_rx;
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         bit e_drop;
         logic [15:0] e_irr, e_imr;
         e_drop = rx_done && (m_rxp[rx_mb] || m_rfp[rx_mb]) && !m_nmc[rx_mb];
         e_irr = '0; e_irr[9] = m_ovr; e_irr[12] = m_wake;
         e_imr = '0; e_imr[9] = m_ien_ovr; e_imr[12] = m_ien_wake;
         chk("R2 model rx_pend", 32'(rx_pend), 32'(m_rxp));
         chk("R2 model rfp_pend", 32'(rfp_pend), 32'(m_rfp));
         chk("R3 model unread", 32'(unread), 32'(m_unr));
         chk("R10 model mb_mask", 32'(mb_mask), 32'(m_msk));
         chk("R10 model nmc_ctl", 32'(nmc_ctl), 32'(m_nmc));
         chk("R5 model irr", 32'(irr), 32'(e_irr));
         chk("R9 model irq_mask", 32'(irq_mask), 32'(e_imr));
         chk("R9 model irq", 32'(irq), 32'((m_ovr && !m_ien_ovr) || (m_wake && !m_ien_wake)));
         chk("R4 model rx_discard", 32'(rx_discard), 32'(e_drop));
         chk("R4 model rx_store", 32'(rx_store), 32'(rx_done && !e_drop));
      end
   end

   task automatic slot();
      @(negedge clk); #0.2;
      rx_done = 0; wr_en = 0;
   endtask
   task automatic tick(input int n);
      repeat (n) slot();
   endtask
   task automatic rx(input int mb, input bit rem);
      slot(); rx_done = 1; rx_mb = 4'(mb); rx_remote = rem;
   endtask
   task automatic wr(input int sel, input logic [15:0] d);
      slot(); wr_en = 1; wr_sel = 3'(sel); wr_data = d;
   endtask
   task automatic rxwr(input int mb, input int sel, input logic [15:0] d);
      slot(); rx_done = 1; rx_mb = 4'(mb); rx_remote = 0;
      wr_en = 1; wr_sel = 3'(sel); wr_data = d;
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [N-1:0] snap_m, snap_n;
      repeat (3) @(negedge clk);
      #0.2;
      chk("R1 reset rx_pend", 32'(rx_pend), 0);
      chk("R1 reset irr", 32'(irr), 0);
      chk("R1 reset irq_mask", 32'(irq_mask), 32'h1200);
      chk("R1 reset irq", 32'(irq), 0);
      rst_n = 1;

      rx(3, 0); #0.3 chk("R2 store idle", 32'(rx_store), 1);
      tick(1); chk("R2 data pend", 32'(rx_pend), 32'h0008);
      rx(5, 1); tick(1); chk("R2 remote pend", 32'(rfp_pend), 32'h0020);

      rx(3, 0); #0.3 chk("R4 discard", 32'(rx_discard), 1);
      chk("R4 no store", 32'(rx_store), 0);
      tick(1); chk("R3 unread", 32'(unread), 32'h0008);
      chk("R3 ovr set", 32'(irr[9]), 1);

      wr(4, 16'h0020); rx(5, 0); #0.3 chk("R4 overwrite", 32'(rx_store), 1);
      tick(1); chk("R4 overwrite pend", 32'(rx_pend), 32'h0028);
      chk("R3 unread 5", 32'(unread), 32'h0028);

      wr(5, 16'hFFFF); tick(1); chk("R5 write ignored", 32'(irr[9]), 1);
      chk("R7 reserved", 32'(irr[11:10]), 0);
      wr(6, 16'h0000); tick(1); chk("R9 irq on", 32'(irq), 1);
      wr(6, 16'h0200); tick(1); chk("R9 irq off", 32'(irq), 0);

      wr(2, 16'h0008); tick(1); chk("R5 still held", 32'(irr[9]), 1);
      wr(3, 16'h0020); tick(1); chk("R5 clear lag", 32'(irr[9]), 1);
      tick(1); chk("R5 cleared by mask", 32'(irr[9]), 0);

      wr(2, 16'hFFFF); wr(3, 16'h0008); rx(3, 0);
      #0.3 chk("R4 masked discard", 32'(rx_discard), 1);
      tick(1); chk("R3 masked no unread", 32'(unread), 0);
      chk("R3 masked no ovr", 32'(irr[9]), 0);

      wr(3, 16'h0000);
      rxwr(7, 0, 16'h0080); tick(1); chk("R8 set wins pend", 32'(rx_pend[7]), 1);
      rxwr(7, 2, 16'h0080); tick(1); chk("R8 set wins unread", 32'(unread[7]), 1);
      wr(0, 16'h0008); tick(1); chk("R8 w1c pend", 32'(rx_pend[3]), 0);

      snap_m = mb_mask; snap_n = nmc_ctl;
      wr(7, 16'hFFFF); tick(1);
      chk("R10 sel7 mask", 32'(mb_mask), 32'(snap_m));
      chk("R10 sel7 nmc", 32'(nmc_ctl), 32'(snap_n));

      sleep_mode = 1;
      slot(); can_rx = 0;
      slot(); chk("R6 after 1 edge", 32'(irr[12]), 0);
      slot(); chk("R6 after 2 edges", 32'(irr[12]), 0);
      slot(); chk("R6 after 3 edges", 32'(irr[12]), 1);
      can_rx = 1;
      wr(5, 16'h0000); tick(3); chk("R7 write 0 keeps", 32'(irr[12]), 1);
      wr(5, 16'h1000); tick(1); chk("R7 write 1 clears", 32'(irr[12]), 0);
      sleep_mode = 0;
      slot(); can_rx = 0; tick(5); chk("R6 awake ignored", 32'(irr[12]), 0);
      can_rx = 1;

      for (int i = 0; i < 4000; i++) begin
         slot();
         rx_done    = ($urandom % 3) == 0;
         rx_mb      = 4'($urandom);
         rx_remote  = $urandom % 2;
         wr_en      = ($urandom % 4) == 0;
         wr_sel     = 3'($urandom);
         wr_data    = 16'($urandom);
         sleep_mode = ($urandom % 4) != 0;
         can_rx     = ($urandom % 8) != 0;
      end
      tick(2);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule